// File: doc/BRIEF.md
# CAN Receive Mailbox Bank

This block holds a bank of receive mailboxes for a CAN controller. A bus-side front end that has already decoded a frame presents it for one cycle: the identifier, the extended flag, the remote flag, the length code and eight payload bytes. The bank tests the frame against the acceptance filter of every mailbox and places it in the lowest-numbered mailbox that is enabled for reception, accepts it and is still empty. A stored mailbox stays full until software re-arms it with a write-one bitmask command.

A mailbox in overwrite mode may take a frame while it is still full. The old contents are replaced and the mailbox raises a lost-message flag. When a frame is accepted but every accepting mailbox is full and none of them overwrites, the frame is dropped and a sticky overrun bit is set. The mailbox ready bits, gated by an interrupt mask, drive a single interrupt line. Software reaches everything through one word-wide write port and one combinational read port.

Address map (word addresses): 0x00 sets interrupt mask bits, 0x01 clears them, 0x02 reads the mask, 0x03 reads status (ready vector in the low bits, overrun at bit 31), 0x04 is the re-arm command. Mailbox n occupies 0x20+8n to 0x20+8n+7. The offsets within a mailbox are: 0 mode, 1 acceptance mask, 2 filter identifier, 3 status, 4 payload bytes 0 to 3, 5 payload bytes 4 to 7, 6 captured identifier.

Top module: `can_rx_mailbox_bank`

## Requirements
- R1: The bank has 12 mailboxes, numbered 0 to 11. After reset every mode is 0, no mailbox is ready, the interrupt mask is 0, the overrun bit is 0 and `irq` is low.
- R2: A valid frame is stored in the lowest-numbered mailbox that is in a receive mode, accepts the frame and is not ready. That mailbox's ready bit shows at 0x03 after the next clock edge.
- R3: The mode sits in bits 26:24 of mailbox offset 0 and reads back as written. 0 means disabled, 1 receive, 2 receive with overwrite and 3 transmit. Only modes 1 and 2 take frames.
- R4: The captured identifier (offset 6) and the filter identifier (offset 2) use one format. A standard identifier sits in bits 28:18 with bit 29 clear. An extended identifier sits in bits 28:0 with bit 29 set.
- R5: A mailbox accepts a frame when the frame's formatted identifier equals the filter identifier on every bit where the acceptance mask (offset 1, bits 28:0) is 1, and the frame's extended flag equals filter bit 29. A mask of zero accepts every identifier of the matching kind.
- R6: The status word (offset 3) carries the length in bits 19:16, the remote flag in bit 20, ready in bit 23 and lost-message in bit 24. Offset 4 returns payload bits 31:0 and offset 5 returns bits 63:32.
- R7: Writing a bitmask to 0x04 clears the ready and lost-message flags of every mailbox whose bit is 1. The other mailboxes are left as they were.
- R8: When no accepting mailbox is free, the lowest accepting mailbox in mode 2 that is full is overwritten. Its lost-message bit is set and the overrun bit is not.
- R9: When a frame is accepted but all accepting mailboxes are full and none is in mode 2, the frame is dropped and status bit 31 is set. The bit holds until a write to 0x03 with bit 31 set.
- R10: Writing 1s to 0x00 sets mask bits and writing 1s to 0x01 clears them. 0x02 reads the mask back. `irq` is high exactly when some mailbox is both ready and unmasked.
- R11: When a frame and a re-arm command arrive in the same cycle, allocation uses the ready state from before the re-arm. If both name the same mailbox, the store wins and the mailbox stays ready.
- R12: A frame that no mailbox accepts changes no mailbox and does not set the overrun bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frmValid | input | 1 | One-cycle strobe of a decoded frame |
| frmId | input | 29 | Raw identifier (standard uses bits 10:0) |
| frmExt | input | 1 | Frame uses an extended identifier |
| frmRtr | input | 1 | Remote-frame flag |
| frmLen | input | 4 | Length code |
| frmData | input | 64 | Payload, byte 0 in bits 7:0 |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register write address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 8 | Register read address |
| rdData | output | 32 | Read data, combinational from rdAddr |
| irq | output | 1 | OR of ready bits gated by the interrupt mask |

## Verification
Two functions can fall in the same cycle: the arrival of a frame and a re-arm command written to 0x04. The bench drives both on one clock edge in two settings. In the first, the lowest mailbox is full and is being re-armed, and the frame must land in the next mailbox while the re-armed one goes empty. In the second, the overwrite mailbox is both re-armed and overwritten, and it must end ready, carry the new payload and keep its lost-message bit. The results are judged through the status vector and the mailbox registers, read after the edge.

// File: rtl/can_rx_mailbox_pkg.sv
package can_rx_mailbox_pkg;

  typedef enum logic [2:0] {
    MODE_OFF   = 3'd0,
    MODE_RX    = 3'd1,
    MODE_RXOVR = 3'd2,
    MODE_TX    = 3'd3
  } mbMode_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic       store;
    logic       storeLost;
    logic       cfgWr;
    logic [2:0] cfgField;
    logic       intSet;
    logic       intClr;
    logic       overrunSet;
    logic       overrunClr;
    logic       rearm;
  } mbStrobe_t;

  localparam int ID_W      = 29;
  localparam int STD_W     = 11;
  localparam int FMT_W     = ID_W + 1;

  localparam int FLD_MODE  = 0;
  localparam int FLD_MASK  = 1;
  localparam int FLD_FILT  = 2;
  localparam int FLD_STAT  = 3;
  localparam int FLD_DLO   = 4;
  localparam int FLD_DHI   = 5;
  localparam int FLD_CAPT  = 6;

  localparam int ADR_IE_SET  = 0;
  localparam int ADR_IE_CLR  = 1;
  localparam int ADR_IE_READ = 2;
  localparam int ADR_STATUS  = 3;
  localparam int ADR_REARM   = 4;

  localparam int MB_BASE      = 32;
  localparam int MB_STRIDE_LG = 3;

  // identifier in register layout: bit 29 = extended
  function automatic logic [FMT_W-1:0] fmtId(input logic [ID_W-1:0] raw, input logic ext);
    if (ext) return {1'b1, raw};
    return {1'b0, raw[STD_W-1:0], {(ID_W-STD_W){1'b0}}};
  endfunction

endpackage

// File: rtl/can_rx_mailbox_ctrl.sv
module can_rx_mailbox_ctrl
  import can_rx_mailbox_pkg::*;
#(
  parameter int NMB    = 12,
  parameter int ADDR_W = 8,
  localparam int IDXW  = $clog2(NMB)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frmValid,
  input  logic [NMB-1:0]    mbAccept,
  input  logic [NMB-1:0]    mbReady,
  input  logic [NMB-1:0]    mbOvr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrTop,
  output mbStrobe_t         st,
  output logic [IDXW-1:0]   storeIdx,
  output logic [IDXW-1:0]   cfgIdx
);

  logic [NMB-1:0]    freeVec, ovrVec;
  logic [IDXW-1:0]   freeIdx, ovrIdx;
  logic              freeHit, ovrHit;
  logic [ADDR_W-1:0] wOff, wSel;
  logic              inMb;

  // lowest free, lowest overwritable
  always_comb begin
    freeVec = mbAccept & ~mbReady;
    ovrVec  = mbAccept & mbReady & mbOvr;
    freeHit = |freeVec;
    ovrHit  = |ovrVec;
    freeIdx = '0;
    ovrIdx  = '0;
    for (int i = NMB - 1; i >= 0; i--) begin
      if (freeVec[i]) freeIdx = IDXW'(i);
      if (ovrVec[i])  ovrIdx  = IDXW'(i);
    end
  end

  always_comb begin
    wOff  = wrAddr - ADDR_W'(MB_BASE);
    wSel  = wOff >> MB_STRIDE_LG;
    inMb  = (wrAddr >= ADDR_W'(MB_BASE)) && (wSel < ADDR_W'(NMB));
    cfgIdx = wSel[IDXW-1:0];

    st            = '0;
    st.store      = frmValid && (freeHit || ovrHit);
    st.storeLost  = frmValid && !freeHit && ovrHit;
    st.overrunSet = frmValid && (|mbAccept) && !freeHit && !ovrHit;
    storeIdx      = freeHit ? freeIdx : ovrIdx;

    st.cfgField   = wOff[2:0];
    st.cfgWr      = wrEn && inMb && (wOff[2:0] <= 3'(FLD_FILT));
    st.intSet     = wrEn && (wrAddr == ADDR_W'(ADR_IE_SET));
    st.intClr     = wrEn && (wrAddr == ADDR_W'(ADR_IE_CLR));
    st.overrunClr = wrEn && (wrAddr == ADDR_W'(ADR_STATUS)) && wrTop;
    st.rearm      = wrEn && (wrAddr == ADDR_W'(ADR_REARM));
  end

  // a plain store goes to an empty mailbox that accepts the frame
  assert_free_target_R2: assert property (@(posedge clk) disable iff (!rstN)
    (st.store && !st.storeLost) |-> (!mbReady[storeIdx] && mbAccept[storeIdx]));

  // a lossy store only hits a full overwrite mailbox
  assert_lost_target_R8: assert property (@(posedge clk) disable iff (!rstN)
    (st.store && st.storeLost) |-> (mbReady[storeIdx] && mbOvr[storeIdx]));

  assert_drop_no_store_R9: assert property (@(posedge clk) disable iff (!rstN)
    st.overrunSet |-> !st.store);

  assert_unmatched_ignored_R12: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && !(|mbAccept)) |-> (!st.store && !st.overrunSet));

endmodule

// File: rtl/can_rx_mailbox_dpath.sv
module can_rx_mailbox_dpath
  import can_rx_mailbox_pkg::*;
#(
  parameter int NMB    = 12,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 64,
  localparam int IDXW  = $clog2(NMB)
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbStrobe_t         st,
  input  logic [IDXW-1:0]   storeIdx,
  input  logic [IDXW-1:0]   cfgIdx,
  input  logic [NMB-1:0]    bitMask,
  input  logic [FMT_W-1:0]  cfgData,
  input  logic [ID_W-1:0]   frmId,
  input  logic              frmExt,
  input  logic              frmRtr,
  input  logic [3:0]        frmLen,
  input  logic [DATA_W-1:0] frmData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic [NMB-1:0]    mbAccept,
  output logic [NMB-1:0]    mbReady,
  output logic [NMB-1:0]    mbOvr,
  output logic              irq
);

  logic [2:0]        modeR [NMB];
  logic [ID_W-1:0]   maskR [NMB];
  logic [FMT_W-1:0]  filtR [NMB];
  logic [FMT_W-1:0]  captR [NMB];
  logic [DATA_W-1:0] dataR [NMB];
  logic [3:0]        lenR  [NMB];
  logic [NMB-1:0]    readyR, lostR, rtrR, intMask;
  logic              overrunR;
  logic [FMT_W-1:0]  frmFmt;

  assign frmFmt = fmtId(frmId, frmExt);

  // acceptance filter, one comparator per mailbox
  always_comb begin
    for (int i = 0; i < NMB; i++) begin
      mbOvr[i]    = (modeR[i] == MODE_RXOVR);
      mbAccept[i] = ((modeR[i] == MODE_RX) || (modeR[i] == MODE_RXOVR)) &&
                    (frmFmt[ID_W] == filtR[i][ID_W]) &&
                    (((frmFmt[ID_W-1:0] ^ filtR[i][ID_W-1:0]) & maskR[i]) == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NMB; i++) begin
        modeR[i] <= MODE_OFF;
        maskR[i] <= '0;
        filtR[i] <= '0;
        captR[i] <= '0;
        dataR[i] <= '0;
        lenR[i]  <= '0;
      end
      readyR   <= '0;
      lostR    <= '0;
      rtrR     <= '0;
      intMask  <= '0;
      overrunR <= 1'b0;
    end else begin
      for (int i = 0; i < NMB; i++) begin
        if (st.cfgWr && cfgIdx == IDXW'(i)) begin
          case (st.cfgField)
            3'(FLD_MODE): modeR[i] <= cfgData[26:24];
            3'(FLD_MASK): maskR[i] <= cfgData[ID_W-1:0];
            3'(FLD_FILT): filtR[i] <= cfgData;
            default: ;
          endcase
        end
        // a store beats a re-arm of the same mailbox
        if (st.store && storeIdx == IDXW'(i)) begin
          readyR[i] <= 1'b1;
          lostR[i]  <= st.storeLost;
          rtrR[i]   <= frmRtr;
          lenR[i]   <= frmLen;
          dataR[i]  <= frmData;
          captR[i]  <= frmFmt;
        end else if (st.rearm && bitMask[i]) begin
          readyR[i] <= 1'b0;
          lostR[i]  <= 1'b0;
        end
      end
      if (st.intSet)      intMask <= intMask | bitMask;
      else if (st.intClr) intMask <= intMask & ~bitMask;
      if (st.overrunSet)      overrunR <= 1'b1;
      else if (st.overrunClr) overrunR <= 1'b0;
    end
  end

  assign mbReady = readyR;
  assign irq     = |(readyR & intMask);

  logic [ADDR_W-1:0] rOff, rSel;
  logic [IDXW-1:0]   rIdx;

  always_comb begin
    rdData = '0;
    rOff   = rdAddr - ADDR_W'(MB_BASE);
    rSel   = rOff >> MB_STRIDE_LG;
    rIdx   = rSel[IDXW-1:0];
    if (rdAddr == ADDR_W'(ADR_IE_READ)) begin
      rdData[NMB-1:0] = intMask;
    end else if (rdAddr == ADDR_W'(ADR_STATUS)) begin
      rdData[NMB-1:0] = readyR;
      rdData[31]      = overrunR;
    end else if (rdAddr >= ADDR_W'(MB_BASE) && rSel < ADDR_W'(NMB)) begin
      case (rOff[2:0])
        3'(FLD_MODE): rdData[26:24]      = modeR[rIdx];
        3'(FLD_MASK): rdData[ID_W-1:0]   = maskR[rIdx];
        3'(FLD_FILT): rdData[FMT_W-1:0]  = filtR[rIdx];
        3'(FLD_STAT): begin
          rdData[19:16] = lenR[rIdx];
          rdData[20]    = rtrR[rIdx];
          rdData[23]    = readyR[rIdx];
          rdData[24]    = lostR[rIdx];
        end
        3'(FLD_DLO):  rdData = dataR[rIdx][31:0];
        3'(FLD_DHI):  rdData = dataR[rIdx][63:32];
        3'(FLD_CAPT): rdData[FMT_W-1:0]  = captR[rIdx];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NMB; g++) begin : g_chk
    assert_store_sets_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
      (st.store && storeIdx == IDXW'(g)) |=> readyR[g]);

    assert_rearm_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
      (st.rearm && bitMask[g] && !(st.store && storeIdx == IDXW'(g))) |=> (!readyR[g] && !lostR[g]));

    // a full mailbox that is neither stored nor re-armed keeps its flag
    assert_full_holds_R11: assert property (@(posedge clk) disable iff (!rstN)
      (readyR[g] && !(st.rearm && bitMask[g])) |=> readyR[g]);
  end

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (overrunR && !st.overrunClr) |=> overrunR);

  assert_mask_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    st.intSet |=> ((intMask & $past(bitMask)) == $past(bitMask)));

endmodule

// File: rtl/can_rx_mailbox_bank.sv
module can_rx_mailbox_bank
  import can_rx_mailbox_pkg::*;
#(
  parameter int NMB    = 12,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 64,
  localparam int IDXW  = $clog2(NMB)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frmValid,
  input  logic [28:0]       frmId,
  input  logic              frmExt,
  input  logic              frmRtr,
  input  logic [3:0]        frmLen,
  input  logic [DATA_W-1:0] frmData,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic              irq
);

  mbStrobe_t       st;
  logic [IDXW-1:0] storeIdx, cfgIdx;
  logic [NMB-1:0]  mbAccept, mbReady, mbOvr;

  can_rx_mailbox_ctrl #(.NMB(NMB), .ADDR_W(ADDR_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .frmValid (frmValid),
    .mbAccept (mbAccept),
    .mbReady  (mbReady),
    .mbOvr    (mbOvr),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrTop    (wrData[31]),
    .st       (st),
    .storeIdx (storeIdx),
    .cfgIdx   (cfgIdx)
  );

  can_rx_mailbox_dpath #(.NMB(NMB), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .storeIdx (storeIdx),
    .cfgIdx   (cfgIdx),
    .bitMask  (wrData[NMB-1:0]),
    .cfgData  (wrData[FMT_W-1:0]),
    .frmId    (frmId),
    .frmExt   (frmExt),
    .frmRtr   (frmRtr),
    .frmLen   (frmLen),
    .frmData  (frmData),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .mbAccept (mbAccept),
    .mbReady  (mbReady),
    .mbOvr    (mbOvr),
    .irq      (irq)
  );

endmodule

// File: tb/can_rx_mailbox_bank_tb.sv
module can_rx_mailbox_bank_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frmValid = 1'b0;
  logic [28:0] frmId = '0;
  logic        frmExt = 1'b0;
  logic        frmRtr = 1'b0;
  logic [3:0]  frmLen = '0;
  logic [63:0] frmData = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  can_rx_mailbox_bank dut_i (
    .clk(clk), .rstN(rstN), .frmValid(frmValid), .frmId(frmId), .frmExt(frmExt),
    .frmRtr(frmRtr), .frmLen(frmLen), .frmData(frmData), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  function automatic logic [7:0] mbAdr(input int mb, input int fld);
    return 8'(32 + mb * 8 + fld);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    rdAddr = a;
    #0.5;
    d = rdData;
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic sendFrm(input logic [28:0] id, input logic ext, input logic rtr,
                         input logic [3:0] len, input logic [63:0] dat,
                         input logic doRearm, input logic [11:0] rm);
    @(negedge clk);
    frmValid = 1'b1; frmId = id; frmExt = ext; frmRtr = rtr; frmLen = len; frmData = dat;
    if (doRearm) begin
      wrEn = 1'b1; wrAddr = 8'h04; wrData = {20'd0, rm};
    end
    @(negedge clk);
    frmValid = 1'b0; wrEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=%h exp=%h", 0, 1);
    finishRun();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdReg(8'h03, v); check("R1 status", v, 32'h0);
    rdReg(8'h02, v); check("R1 intmask", v, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);
    for (int i = 0; i < 12; i++) begin
      rdReg(mbAdr(i, 0), v); check("R1 mode", v, 32'h0);
    end

    // R3 configure all as plain receive
    for (int i = 0; i < 12; i++) begin
      wrReg(mbAdr(i, 0), 32'h0100_0000);
      wrReg(mbAdr(i, 1), 32'h0);
      wrReg(mbAdr(i, 2), 32'h0);
    end
    for (int i = 0; i < 12; i++) begin
      rdReg(mbAdr(i, 0), v); check("R3 mode readback", v, 32'h0100_0000);
    end

    // R2 fill in ascending order
    for (int i = 0; i < 12; i++) begin
      sendFrm(29'(i * 37 + 5), 1'b0, 1'(i % 2), 4'(i % 9),
              {32'(i * 32'h0101_0101), 32'hA500_0000 | 32'(i)}, 1'b0, '0);
      rdReg(8'h03, v); check("R2 fill", v, 32'((1 << (i + 1)) - 1));
    end
    for (int i = 0; i < 12; i++) begin
      rdReg(mbAdr(i, 6), v); check("R4 std capture", v, 32'(i * 37 + 5) << 18);
      rdReg(mbAdr(i, 3), v);
      check("R6 status word", v, (32'(i % 9) << 16) | (32'(i % 2) << 20) | 32'h0080_0000);
      rdReg(mbAdr(i, 4), v); check("R6 data lo", v, 32'hA500_0000 | 32'(i));
      rdReg(mbAdr(i, 5), v); check("R6 data hi", v, 32'(i * 32'h0101_0101));
    end

    // R9 overrun
    sendFrm(29'h55, 1'b0, 1'b0, 4'd1, 64'h1, 1'b0, '0);
    rdReg(8'h03, v); check("R9 overrun set", v, 32'h8000_0FFF);
    rdReg(mbAdr(0, 4), v); check("R9 dropped frame", v, 32'hA500_0000);
    wrReg(8'h03, 32'h0);
    rdReg(8'h03, v); check("R9 sticky", v, 32'h8000_0FFF);
    wrReg(8'h03, 32'h8000_0000);
    rdReg(8'h03, v); check("R9 cleared", v, 32'h0000_0FFF);

    // R7 re-arm subset
    wrReg(8'h04, 32'h0A5);
    rdReg(8'h03, v); check("R7 rearm", v, 32'h0F5A);
    sendFrm(29'h10, 1'b0, 1'b0, 4'd2, 64'h2, 1'b0, '0);
    rdReg(8'h03, v); check("R2 lowest rearmed", v, 32'h0F5B);
    sendFrm(29'h11, 1'b0, 1'b0, 4'd2, 64'h3, 1'b0, '0);
    rdReg(8'h03, v); check("R2 next rearmed", v, 32'h0F5F);

    // R11 frame and re-arm in one cycle
    wrReg(8'h04, 32'hFFF);
    sendFrm(29'h20, 1'b0, 1'b0, 4'd0, 64'h0, 1'b0, '0);
    rdReg(8'h03, v); check("R11 prep", v, 32'h1);
    sendFrm(29'h21, 1'b0, 1'b0, 4'd3, 64'h77, 1'b1, 12'h001);
    rdReg(8'h03, v); check("R11 uses pre-rearm state", v, 32'h2);
    rdReg(mbAdr(1, 6), v); check("R11 target id", v, 32'h21 << 18);

    // R8 overwrite on the top mailbox
    wrReg(8'h04, 32'hFFF);
    wrReg(mbAdr(11, 0), 32'h0200_0000);
    for (int i = 0; i < 12; i++) sendFrm(29'(i), 1'b0, 1'b0, 4'd1, 64'(i), 1'b0, '0);
    rdReg(8'h03, v); check("R8 full", v, 32'hFFF);
    rdReg(mbAdr(11, 3), v); check("R8 no loss yet", v, 32'h0081_0000);
    sendFrm(29'h3AA, 1'b0, 1'b1, 4'd8, 64'hDEAD_BEEF_0000_1111, 1'b0, '0);
    rdReg(8'h03, v); check("R8 no overrun", v, 32'hFFF);
    rdReg(mbAdr(11, 3), v); check("R8 lost flag", v, 32'h0198_0000);
    rdReg(mbAdr(11, 5), v); check("R8 new data", v, 32'hDEAD_BEEF);
    sendFrm(29'h3AB, 1'b0, 1'b0, 4'd4, 64'h0000_0000_CAFE_0001, 1'b1, 12'h800);
    rdReg(mbAdr(11, 3), v); check("R11 store beats rearm", v, 32'h0184_0000);
    rdReg(mbAdr(11, 4), v); check("R11 store data", v, 32'hCAFE_0001);
    wrReg(8'h04, 32'h800);
    rdReg(mbAdr(11, 3), v); check("R7 rearm clears lost", v & 32'h0180_0000, 32'h0);

    // R3 only receive modes take frames
    wrReg(8'h04, 32'hFFF);
    wrReg(mbAdr(0, 0), 32'h0300_0000);
    wrReg(mbAdr(1, 0), 32'h0000_0000);
    sendFrm(29'h7, 1'b0, 1'b0, 4'd0, 64'h0, 1'b0, '0);
    rdReg(8'h03, v); check("R3 skip tx and off", v, 32'h4);

    // R5 / R12 filter sweeps
    wrReg(8'h04, 32'hFFF);
    for (int i = 0; i < 12; i++) wrReg(mbAdr(i, 0), (i == 3 || i == 5) ? 32'h0100_0000 : 32'h0);
    wrReg(mbAdr(3, 1), 32'h1FFC_0000);
    wrReg(mbAdr(3, 2), 32'h123 << 18);
    wrReg(mbAdr(5, 1), 32'h1FFF_FF00);
    wrReg(mbAdr(5, 2), 32'h2000_0000 | 32'h0ABC_DE00);
    for (int k = 0; k < 8; k++) begin
      sendFrm(29'(32'h120 + k), 1'b0, 1'b0, 4'd0, 64'h0, 1'b0, '0);
      rdReg(8'h03, v);
      check((k == 3) ? "R5 std match" : "R12 std miss", v, (k == 3) ? 32'h8 : 32'h0);
      wrReg(8'h04, 32'hFFF);
    end
    for (int k = 0; k < 8; k++) begin
      sendFrm(29'(32'h0ABC_DE00 | 32'(k * 33)), 1'b1, 1'b0, 4'd0, 64'h0, 1'b0, '0);
      rdReg(8'h03, v); check("R5 ext masked low bits", v, 32'h20);
      wrReg(8'h04, 32'hFFF);
      sendFrm(29'(32'h0ABC_DF00 | 32'(k)), 1'b1, 1'b0, 4'd0, 64'h0, 1'b0, '0);
      rdReg(8'h03, v); check("R12 ext miss", v, 32'h0);
    end
    sendFrm(29'h123, 1'b1, 1'b0, 4'd0, 64'h0, 1'b0, '0);
    rdReg(8'h03, v); check("R5 ext flag must match", v, 32'h0);
    wrReg(mbAdr(5, 1), 32'h0);
    sendFrm(29'h1555_5555, 1'b1, 1'b0, 4'd0, 64'h0, 1'b0, '0);
    rdReg(8'h03, v); check("R5 zero mask ext", v, 32'h20);
    rdReg(mbAdr(5, 6), v); check("R4 ext capture", v, 32'h3555_5555);
    wrReg(8'h04, 32'hFFF);
    sendFrm(29'h7FF, 1'b0, 1'b0, 4'd0, 64'h0, 1'b0, '0);
    rdReg(8'h03, v); check("R12 std vs ext filter", v, 32'h0);

    // R10 interrupt mask
    sendFrm(29'h123, 1'b0, 1'b0, 4'd0, 64'h0, 1'b0, '0);
    rdReg(8'h03, v); check("R10 prep", v, 32'h8);
    check("R10 masked irq", {31'd0, irq}, 32'h0);
    for (int b = 0; b < 12; b++) begin
      wrReg(8'h00, 32'(1 << b));
      rdReg(8'h02, v); check("R10 mask read", v, 32'(1 << b));
      check("R10 irq", {31'd0, irq}, (b == 3) ? 32'h1 : 32'h0);
      wrReg(8'h01, 32'(1 << b));
      check("R10 irq after clear", {31'd0, irq}, 32'h0);
    end
    wrReg(8'h00, 32'hFFF);
    check("R10 irq all", {31'd0, irq}, 32'h1);
    wrReg(8'h04, 32'h008);
    check("R10 irq follows ready", {31'd0, irq}, 32'h0);

    finishRun();
  end

endmodule